// File: doc/BRIEF.md
# Programmable-Rate Periodic Interrupt Generator

This block raises a periodic interrupt at a rate that software picks from six values, from 256 Hz down to 1 Hz. It does not keep its own time base. A clock prescaler elsewhere supplies a single-cycle pulse 256 times per second, and the block divides that pulse by 1, 4, 16, 64, 128 or 256. Each time the selected count of base pulses completes, a sticky event flag sets. The interrupt line follows that flag for as long as a valid rate is selected.

Software reaches the block through one byte-wide control register. Bit 7 is the event flag, bits 6:4 are the rate code, and bits 3:0 are general control bits that this block only stores and returns. Software clears the flag by writing the register back with bit 7 at 0. A write with bit 7 at 1 leaves the flag as it was.

Each write that changes the rate code restarts the divider, so the first period at the new rate is always a full one. Rate control runs as a two-state machine. ST_OFF is entered from reset, and from ST_RUN when a write loads code 0 or 7. ST_RUN is entered from ST_OFF when a write loads a code from 1 to 6. ST_RUN returns to ST_RUN when a write changes the code to another valid value, and this restarts the divider.

Top module: `pirq_rate_gen`

## Requirements
- R1: After reset the control register reads 0x00 and `irq_o` is low.
- R2: With rate code 1, every base tick sets the flag (bit 7), visible in the cycle after the tick.
- R3: Rate codes 2, 3, 4, 5 and 6 set the flag on the 4th, 16th, 64th, 128th and 256th base tick after the code was loaded, and not on any earlier tick.
- R4: Rate codes 0 and 7 disable the block: ticks never set the flag, and `irq_o` stays low.
- R5: Once set, the flag stays set until a register write with bit 7 = 0 clears it. A write with bit 7 = 1 does not change the flag.
- R6: `irq_o` equals the flag while the rate code is 1 to 6. While the code is 0 or 7, a flag that is already set stays readable in bit 7, but `irq_o` is low.
- R7: A write that changes the rate code restarts the divider. A write that keeps the same code does not restart it.
- R8: Bits 3:0 read back exactly as last written, whatever the flag or the divider do.
- R9: When a flag-setting tick and a clearing write land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse from the prescaler, 256 per second |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Write data: bit 7 flag (0 clears), bits 6:4 rate code, bits 3:0 stored control bits |
| rd_data_o | output | 8 | Current control register contents |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
The bench counts base ticks one at a time for every rate code and checks the tick before the expected one as well as the expected one, so a divisor that is off by one or assigned to the wrong code is caught. The tests for codes 0 and 7 catch a block that still counts or still signals while disabled. The masking test catches a block that wipes a pending flag when it is switched off. Two tests separate a code change, which must restart the divider, from a same-code rewrite that only clears the flag, which must not; getting either wrong stretches or shortens a period. A tick that lands in the same cycle as a clearing write exposes a block that lets the clear win and loses the event.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic [0:0] {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } pirq_state_e;

    localparam int RATE_W = 3;

    // codes 1..6 select a rate; 0 and 7 mean off
    function automatic logic rate_valid(input logic [RATE_W-1:0] code);
        return (code != '0) && (code != '1);
    endfunction

endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode #(
    parameter int DIV_W = 8
) (
    input  logic [pirq_pkg::RATE_W-1:0] code_i,
    output logic [DIV_W-1:0]            lim_o,
    output logic                        valid_o
);
    localparam int FW = DIV_W + 1;

    logic [3:0]    shift;
    logic [FW-1:0] span;

    always_comb begin
        valid_o = 1'b1;
        unique case (code_i)
            3'd1:    shift = 4'd0;
            3'd2:    shift = 4'd2;
            3'd3:    shift = 4'd4;
            3'd4:    shift = 4'd6;
            3'd5:    shift = 4'd7;
            3'd6:    shift = 4'd8;
            default: begin
                shift   = 4'd0;
                valid_o = 1'b0;
            end
        endcase
        span  = FW'(1) << shift;
        lim_o = DIV_W'(span - FW'(1));
    end
endmodule

// File: rtl/pirq_divider.sv
module pirq_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             hit_o
);
    logic [DIV_W-1:0] cnt_q;

    assign hit_o = run_i && tick_i && !restart_i && (cnt_q == lim_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= lim_i);

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> cnt_q == '0);
endmodule

// File: rtl/pirq_fsm.sv
module pirq_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic new_valid_i,
    output logic run_o
);
    import pirq_pkg::*;

    pirq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_i && new_valid_i)  state_d = ST_RUN;
            ST_RUN: if (wr_i && !new_valid_i) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o = (state_q == ST_RUN);
    end
endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import pirq_pkg::*;

    localparam int FLAG_BIT = DATA_W - 1;
    localparam int RATE_LO  = FLAG_BIT - RATE_W;
    localparam int LOW_W    = RATE_LO;

    logic              flag_q;
    logic [RATE_W-1:0] rate_q;
    logic [LOW_W-1:0]  low_q;

    logic [RATE_W-1:0] wr_rate;
    logic              restart;
    logic              run;
    logic              hit;
    logic              rate_ok;
    logic [DIV_W-1:0]  lim;

    assign wr_rate = wr_data_i[FLAG_BIT-1:RATE_LO];
    assign restart = wr_en_i && (wr_rate != rate_q);

    pirq_rate_decode #(.DIV_W(DIV_W)) u_decode (
        .code_i  (rate_q),
        .lim_o   (lim),
        .valid_o (rate_ok)
    );

    pirq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_en_i),
        .new_valid_i (rate_valid(wr_rate)),
        .run_o       (run)
    );

    pirq_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run && rate_ok),
        .restart_i (restart),
        .tick_i    (tick_i),
        .lim_i     (lim),
        .hit_o     (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            rate_q <= '0;
            low_q  <= '0;
        end else begin
            if (hit)                                flag_q <= 1'b1;
            else if (wr_en_i && !wr_data_i[FLAG_BIT]) flag_q <= 1'b0;
            if (wr_en_i) begin
                rate_q <= wr_rate;
                low_q  <= wr_data_i[LOW_W-1:0];
            end
        end
    end

    assign rd_data_o = {flag_q, rate_q, low_q};
    assign irq_o     = flag_q && run;

    // R4
    off_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_valid(rate_q) |-> !irq_o);

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en_i && !wr_data_i[FLAG_BIT])) |=> flag_q);

    // R9
    hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    // R8
    low_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rd_data_o[LOW_W-1:0]));
endmodule

// File: tb/pirq_rate_gen_bench.sv
module pirq_rate_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pirq_rate_gen u_pirq_rate_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1 reg", rd_data_o, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h01 & 8'h00);
    endtask

    task automatic t_rate(input logic [2:0] code, input int div, input string req);
        do_write(8'h00);
        do_write({1'b0, code, 4'h0});
        do_ticks(div - 1);
        check(req, {7'd0, rd_data_o[7]}, 8'h00);
        do_ticks(1);
        check(req, {7'd0, rd_data_o[7]}, 8'h01);
        check({req, " irq (R6)"}, {7'd0, irq_o}, 8'h01);
        do_write({1'b0, code, 4'h0});
        check({req, " clear (R5)"}, {7'd0, rd_data_o[7]}, 8'h00);
    endtask

    task automatic t_disabled();
        do_write(8'h00);
        do_ticks(20);
        check("R4 code0 flag", rd_data_o, 8'h00);
        check("R4 code0 irq", {7'd0, irq_o}, 8'h00);
        do_write(8'h70);
        do_ticks(20);
        check("R4 code7 flag", rd_data_o, 8'h70);
        check("R4 code7 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_sticky();
        do_write(8'h10);
        do_ticks(1);
        do_write(8'h90);
        check("R5 write1 keeps", rd_data_o, 8'h90);
        do_ticks(3);
        check("R5 stays set", rd_data_o, 8'h90);
        do_write(8'h10);
        check("R5 write0 clears", rd_data_o, 8'h10);
    endtask

    task automatic t_mask();
        do_write(8'h10);
        do_ticks(1);
        do_write(8'h80);
        check("R6 flag kept when off", rd_data_o, 8'h80);
        check("R6 irq masked", {7'd0, irq_o}, 8'h00);
        do_write(8'h90);
        check("R6 irq back", {7'd0, irq_o}, 8'h01);
        do_write(8'h10);
    endtask

    task automatic t_restart();
        do_write(8'h00);
        do_write(8'h20);
        do_ticks(3);
        do_write(8'h30);
        do_ticks(15);
        check("R7 restart no early", {7'd0, rd_data_o[7]}, 8'h00);
        do_ticks(1);
        check("R7 restart full period", {7'd0, rd_data_o[7]}, 8'h01);
        do_write(8'h00);
        do_write(8'h20);
        do_ticks(2);
        do_write(8'h20);
        do_ticks(2);
        check("R7 same code keeps count", {7'd0, rd_data_o[7]}, 8'h01);
        do_write(8'h20);
    endtask

    task automatic t_low();
        do_write(8'h1A);
        do_ticks(2);
        check("R8 low bits", rd_data_o, 8'h9A);
        do_write(8'h15);
        check("R8 low bits rewrite", rd_data_o, 8'h15);
    endtask

    task automatic t_collide();
        do_write(8'h10);
        @(negedge clk);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h10;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        check("R9 set wins", {7'd0, rd_data_o[7]}, 8'h01);
        do_write(8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rate(3'd1, 1, "R2 code1");
        t_rate(3'd2, 4, "R3 code2");
        t_rate(3'd3, 16, "R3 code3");
        t_rate(3'd4, 64, "R3 code4");
        t_rate(3'd5, 128, "R3 code5");
        t_rate(3'd6, 256, "R3 code6");
        t_disabled();
        t_sticky();
        t_mask();
        t_restart();
        t_low();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule